// File: doc/BRIEF.md
# DMA channel address sequencer

This block produces the source and destination addresses for a single DMA channel. A transfer is one or more buffers of a programmed number of beats. Each accepted beat advances both addresses by the element size. At every buffer boundary, each side picks its next address on its own terms. It can carry straight on (contiguous), return to the address it had when the channel was started (replay), or take an address from a descriptor read out of memory (list). When either side uses a list, the block reads a four-word descriptor through a simple request/valid port at the start of every buffer. The descriptor's length and next pointer then govern the transfer.

Either side can also walk a rectangle inside a wider stored image. After each picture-width run of beats, the address skips the gap to the next line. A lock output tells the bus arbiter to keep the channel granted for one of three scopes: the whole transfer, the current buffer, or the current chunk. A one-cycle pulse marks completion. The channel then returns to idle and accepts a new start.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset the block is idle: busy_o, active_o, lock_o, done_o and desc_req_o are all 0.
- R2: A contiguous side (mode 0) advances its address by 1, 2 or 4 bytes per accepted beat, for width_i 0, 1 or 2 (3 acts as 2). The address keeps advancing across buffer boundaries. It holds while no beat is accepted.
- R3: A replay side (mode 1) returns to the address latched at start after the last beat of every buffer.
- R4: When either side is in list mode (mode 2), a descriptor is read at the start of every buffer, the first one included. The descriptor is four words at ptr, ptr+4, ptr+8 and ptr+12, holding in that order the source address, destination address, length in beats and next pointer. The first pointer is desc_ptr_i. Later pointers come from the previous descriptor. A next pointer of 0 ends the transfer after that buffer. desc_req_o is only high outside beat phases.
- R5: A side not in list mode ignores its address word in the descriptor.
- R6: With picture mode on for a side, its address gains an extra (img_w_i - pic_w_i) elements after every pic_w_i beats. The line count then restarts from zero.
- R7: After the last beat of the transfer, done_o is high for exactly one cycle and busy_o is low in that same cycle.
- R8: A start_i pulse while busy is ignored: addresses and progress are unaffected.
- R9: With lock scope 1, lock_o is high for every cycle the channel is busy.
- R10: With lock scope 2, lock_o is high during beat phases and low while a descriptor is being read.
- R11: With lock scope 3, lock_o is high from the first beat of a chunk of chunk_i beats until that chunk completes. It drops between chunks and at buffer ends.
- R12: Without list mode, the transfer ends after nbuf_i buffers of len_i beats each. len_i and nbuf_i must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | start pulse, accepted when idle |
| src_mode_i | input | 2 | source buffer method: 0 contiguous, 1 replay, 2 list |
| dst_mode_i | input | 2 | destination buffer method, same encoding |
| width_i | input | 2 | element size: 0 byte, 1 half, 2 word |
| src_base_i | input | AW | source start address |
| dst_base_i | input | AW | destination start address |
| len_i | input | LW | beats per buffer (non-list) |
| nbuf_i | input | NBW | buffers per transfer (non-list) |
| desc_ptr_i | input | AW | first descriptor address |
| src_pip_i | input | 1 | picture mode on source |
| dst_pip_i | input | 1 | picture mode on destination |
| pic_w_i | input | PW | picture width in elements |
| img_w_i | input | PW | image width in elements |
| lock_scope_i | input | 2 | 0 off, 1 transfer, 2 buffer, 3 chunk |
| chunk_i | input | LW | beats per chunk |
| beat_i | input | 1 | beat accepted this cycle |
| desc_req_o | output | 1 | descriptor word request |
| desc_addr_o | output | AW | descriptor word address |
| desc_valid_i | input | 1 | descriptor word returned |
| desc_data_i | input | AW | descriptor word data |
| src_addr_o | output | AW | current source address |
| dst_addr_o | output | AW | current destination address |
| active_o | output | 1 | beat phase, beats accepted |
| busy_o | output | 1 | transfer in progress |
| lock_o | output | 1 | keep bus grant |
| done_o | output | 1 | completion pulse |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 16-bit lengths and chunk counts, 8-bit buffer counts and 12-bit picture widths. These widths admit the full descriptor address word, so the unused-word case and the zero next-pointer end can be driven directly. Small lengths and a 3-of-8 picture window make every buffer boundary, hole skip and chunk edge fall within a few beats of each other, which keeps each scenario short.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {CHAIN_CONTIG = 2'd0, CHAIN_REPLAY = 2'd1,
                            CHAIN_LIST = 2'd2, CHAIN_RSVD = 2'd3} chain_e;
  typedef enum logic [1:0] {LOCK_OFF = 2'd0, LOCK_XFER = 2'd1,
                            LOCK_BUF = 2'd2, LOCK_CHUNK = 2'd3} lock_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_FETCH = 2'd1,
                            ST_MOVE = 2'd2} st_e;
  localparam int DESC_WORDS = 4;
endpackage

// File: rtl/dma_side_addr.sv
module dma_side_addr
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic [AW-1:0] base_i,
  input  chain_e        mode_i,
  input  logic [AW-1:0] step_i,
  input  logic          pip_i,
  input  logic [PW-1:0] pic_w_i,
  input  logic [AW-1:0] hole_i,
  input  logic          beat_i,
  input  logic          buf_end_i,
  input  logic          desc_ld_i,
  input  logic [AW-1:0] desc_addr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q, first_q, step_q, hole_q, adv;
  logic [PW-1:0] line_q, pic_w_q, line_nxt;
  chain_e        mode_q;
  logic          pip_q, wrap;

  always_comb begin
    line_nxt = line_q + PW'(1);
    wrap     = pip_q && (line_nxt == pic_w_q);
    adv      = addr_q + step_q + (wrap ? hole_q : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      first_q <= '0;
      step_q  <= '0;
      hole_q  <= '0;
      line_q  <= '0;
      pic_w_q <= '0;
      mode_q  <= CHAIN_CONTIG;
      pip_q   <= 1'b0;
    end else if (init_i) begin
      addr_q  <= base_i;
      first_q <= base_i;
      step_q  <= step_i;
      hole_q  <= hole_i;
      line_q  <= '0;
      pic_w_q <= pic_w_i;
      mode_q  <= mode_i;
      pip_q   <= pip_i;
    end else if (desc_ld_i && mode_q == CHAIN_LIST) begin
      addr_q <= desc_addr_i;
      line_q <= '0;
    end else if (beat_i) begin
      if (buf_end_i && (mode_q == CHAIN_REPLAY || mode_q == CHAIN_LIST)) begin
        if (mode_q == CHAIN_REPLAY) addr_q <= first_q;
        line_q <= '0;
      end else begin
        addr_q <= adv;
        line_q <= wrap ? '0 : line_nxt;
      end
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int LW  = 16,
  parameter int NBW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          list_i,
  input  logic [LW-1:0] len_i,
  input  logic [NBW-1:0] nbuf_i,
  input  logic [AW-1:0] desc_ptr_i,
  input  lock_e         scope_i,
  input  logic [LW-1:0] chunk_i,
  input  logic          beat_i,
  input  logic          desc_valid_i,
  input  logic [AW-1:0] desc_data_i,
  output logic          init_o,
  output logic          beat_o,
  output logic          buf_end_o,
  output logic [1:0]    desc_ld_o,
  output logic          desc_req_o,
  output logic [AW-1:0] desc_addr_o,
  output logic          active_o,
  output logic          busy_o,
  output logic          lock_o,
  output logic          done_o
);
  localparam int WIW = $clog2(DESC_WORDS);

  st_e            st_q;
  lock_e          scope_q;
  logic [AW-1:0]  ptr_q, nxt_q, len_q, beat_q;
  logic [WIW-1:0] widx_q;
  logic [NBW-1:0] bufs_q;
  logic [LW-1:0]  chunk_q, ccnt_q;
  logic           list_q, done_q, last;

  assign init_o    = start_i && st_q == ST_IDLE;
  assign beat_o    = beat_i && st_q == ST_MOVE;
  assign last      = beat_o && (beat_q == len_q - AW'(1));
  assign buf_end_o = last;

  for (genvar g = 0; g < 2; g++) begin : g_ld
    assign desc_ld_o[g] = st_q == ST_FETCH && desc_valid_i && widx_q == WIW'(g);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      scope_q <= LOCK_OFF;
      ptr_q   <= '0;
      nxt_q   <= '0;
      len_q   <= '0;
      beat_q  <= '0;
      widx_q  <= '0;
      bufs_q  <= '0;
      chunk_q <= '0;
      ccnt_q  <= '0;
      list_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          scope_q <= scope_i;
          chunk_q <= chunk_i;
          list_q  <= list_i;
          ptr_q   <= desc_ptr_i;
          len_q   <= AW'(len_i);
          bufs_q  <= nbuf_i;
          beat_q  <= '0;
          ccnt_q  <= '0;
          widx_q  <= '0;
          st_q    <= list_i ? ST_FETCH : ST_MOVE;
        end
        ST_FETCH: if (desc_valid_i) begin
          widx_q <= widx_q + WIW'(1);
          if (widx_q == WIW'(2)) len_q <= desc_data_i;
          if (widx_q == WIW'(DESC_WORDS - 1)) begin
            nxt_q  <= desc_data_i;
            beat_q <= '0;
            st_q   <= ST_MOVE;
          end
        end
        ST_MOVE: if (beat_i) begin
          ccnt_q <= (last || ccnt_q + LW'(1) == chunk_q) ? '0 : ccnt_q + LW'(1);
          beat_q <= last ? '0 : beat_q + AW'(1);
          if (last) begin
            if (list_q) begin
              if (nxt_q == '0) begin
                done_q <= 1'b1;
                st_q   <= ST_IDLE;
              end else begin
                ptr_q  <= nxt_q;
                widx_q <= '0;
                st_q   <= ST_FETCH;
              end
            end else if (bufs_q <= NBW'(1)) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              bufs_q <= bufs_q - NBW'(1);
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (scope_q)
      LOCK_XFER:  lock_o = st_q != ST_IDLE;
      LOCK_BUF:   lock_o = st_q == ST_MOVE;
      LOCK_CHUNK: lock_o = st_q == ST_MOVE && ccnt_q != '0;
      default:    lock_o = 1'b0;
    endcase
  end

  assign desc_req_o  = st_q == ST_FETCH;
  assign desc_addr_o = ptr_q + AW'({widx_q, 2'b00});
  assign active_o    = st_q == ST_MOVE;
  assign busy_o      = st_q != ST_IDLE;
  assign done_o      = done_q;
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int LW  = 16,
  parameter int NBW = 8,
  parameter int PW  = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [1:0]     src_mode_i,
  input  logic [1:0]     dst_mode_i,
  input  logic [1:0]     width_i,
  input  logic [AW-1:0]  src_base_i,
  input  logic [AW-1:0]  dst_base_i,
  input  logic [LW-1:0]  len_i,
  input  logic [NBW-1:0] nbuf_i,
  input  logic [AW-1:0]  desc_ptr_i,
  input  logic           src_pip_i,
  input  logic           dst_pip_i,
  input  logic [PW-1:0]  pic_w_i,
  input  logic [PW-1:0]  img_w_i,
  input  logic [1:0]     lock_scope_i,
  input  logic [LW-1:0]  chunk_i,
  input  logic           beat_i,
  output logic           desc_req_o,
  output logic [AW-1:0]  desc_addr_o,
  input  logic           desc_valid_i,
  input  logic [AW-1:0]  desc_data_i,
  output logic [AW-1:0]  src_addr_o,
  output logic [AW-1:0]  dst_addr_o,
  output logic           active_o,
  output logic           busy_o,
  output logic           lock_o,
  output logic           done_o
);
  logic          init, beat_acc, buf_end;
  logic [1:0]    desc_ld;
  logic [1:0]    shamt;
  logic [AW-1:0] step, hole;
  logic [AW-1:0] base [2];
  logic [AW-1:0] addr [2];
  chain_e        mode [2];
  logic [1:0]    pip;
  logic          any_list;

  assign shamt    = (width_i == 2'd3) ? 2'd2 : width_i;
  assign step     = AW'(1) << shamt;
  assign hole     = AW'(img_w_i - pic_w_i) << shamt;
  assign base[0]  = src_base_i;
  assign base[1]  = dst_base_i;
  assign mode[0]  = chain_e'(src_mode_i);
  assign mode[1]  = chain_e'(dst_mode_i);
  assign pip      = {dst_pip_i, src_pip_i};
  assign any_list = mode[0] == CHAIN_LIST || mode[1] == CHAIN_LIST;

  dma_seq_ctrl #(.AW(AW), .LW(LW), .NBW(NBW)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .list_i      (any_list),
    .len_i, .nbuf_i, .desc_ptr_i,
    .scope_i     (lock_e'(lock_scope_i)),
    .chunk_i, .beat_i, .desc_valid_i, .desc_data_i,
    .init_o      (init),
    .beat_o      (beat_acc),
    .buf_end_o   (buf_end),
    .desc_ld_o   (desc_ld),
    .desc_req_o, .desc_addr_o, .active_o, .busy_o, .lock_o, .done_o
  );

  for (genvar g = 0; g < 2; g++) begin : g_side
    dma_side_addr #(.AW(AW), .PW(PW)) u_side (
      .clk_i, .rst_ni,
      .init_i      (init),
      .base_i      (base[g]),
      .mode_i      (mode[g]),
      .step_i      (step),
      .pip_i       (pip[g]),
      .pic_w_i,
      .hole_i      (hole),
      .beat_i      (beat_acc),
      .buf_end_i   (buf_end),
      .desc_ld_i   (desc_ld[g]),
      .desc_addr_i (desc_data_i),
      .addr_o      (addr[g])
    );
  end

  assign src_addr_o = addr[0];
  assign dst_addr_o = addr[1];
endmodule

module dma_addr_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          beat_i,
  input logic          desc_req_o,
  input logic [AW-1:0] src_addr_o,
  input logic [AW-1:0] dst_addr_o,
  input logic          active_o,
  input logic          busy_o,
  input logic          lock_o,
  input logic          done_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R7
  AST_IDLE_NO_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !lock_o); // R9
  AST_FETCH_NOT_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_req_o |-> (busy_o && !active_o)); // R4
  AST_HOLD_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !beat_i) |=> $stable(src_addr_o)); // R2
  AST_HOLD_DST_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && start_i && !beat_i) |=> $stable(dst_addr_o)); // R8
endmodule

bind dma_addr_seq dma_addr_seq_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .start_i, .beat_i, .desc_req_o, .src_addr_o, .dst_addr_o,
  .active_o, .busy_o, .lock_o, .done_o
);

// File: tb/tb_dma_addr_seq.sv
module tb_dma_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, LW = 16, NBW = 8, PW = 12;

  logic clk = 0, rst_n = 0;
  logic start = 0, src_pip = 0, dst_pip = 0, beat = 0, dvalid = 0;
  logic [1:0] src_mode = 0, dst_mode = 0, width = 0, scope = 0;
  logic [AW-1:0] src_base = 0, dst_base = 0, dptr = 0, ddata = 0;
  logic [LW-1:0] len = 1, chunk = 0;
  logic [NBW-1:0] nbuf = 1;
  logic [PW-1:0] pic_w = 0, img_w = 0;
  logic dreq, active, busy, lock, done;
  logic [AW-1:0] daddr, src_a, dst_a;

  int total = 0, bad = 0;
  int nfetch = 0, fetch_lock = 0;
  logic [AW-1:0] flog [8];
  logic finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_addr_seq #(.AW(AW), .LW(LW), .NBW(NBW), .PW(PW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .src_mode_i(src_mode),
    .dst_mode_i(dst_mode), .width_i(width), .src_base_i(src_base),
    .dst_base_i(dst_base), .len_i(len), .nbuf_i(nbuf), .desc_ptr_i(dptr),
    .src_pip_i(src_pip), .dst_pip_i(dst_pip), .pic_w_i(pic_w), .img_w_i(img_w),
    .lock_scope_i(scope), .chunk_i(chunk), .beat_i(beat),
    .desc_req_o(dreq), .desc_addr_o(daddr), .desc_valid_i(dvalid),
    .desc_data_i(ddata), .src_addr_o(src_a), .dst_addr_o(dst_a),
    .active_o(active), .busy_o(busy), .lock_o(lock), .done_o(done)
  );

  function automatic logic [AW-1:0] mem(input logic [AW-1:0] a);
    case (a)
      32'h40: mem = 32'h3000;
      32'h44: mem = 32'hDEAD;
      32'h48: mem = 32'd2;
      32'h4C: mem = 32'h80;
      32'h80: mem = 32'h5000;
      32'h84: mem = 32'hBEEF;
      32'h88: mem = 32'd1;
      default: mem = 32'h0;
    endcase
  endfunction

  // descriptor responder: one word every other cycle
  always @(negedge clk) begin
    if (dreq && !dvalid) begin
      dvalid = 1;
      ddata = mem(daddr);
      if (nfetch < 8) flog[nfetch] = daddr;
      nfetch++;
      if (lock) fetch_lock++;
    end else dvalid = 0;
  end

  task automatic chk(input logic [AW-1:0] act, exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic go();
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_active();
    for (int i = 0; i < 100 && !active; i++) @(negedge clk);
  endtask

  task automatic do_beat(input logic [AW-1:0] es, ed, input string req);
    wait_active();
    chk(src_a, es, req);
    chk(dst_a, ed, req);
    beat = 1;
    @(negedge clk);
    beat = 0;
  endtask

  task automatic end_check();
    chk(done, 1, "R7 done");
    chk(busy, 0, "R7 busy");
    @(negedge clk);
    chk(done, 0, "R7 pulse");
  endtask

  task automatic t_reset();
    chk({busy, active, lock, done, dreq}, 0, "R1");
  endtask

  // contiguous, word width, 2 buffers of 3, transfer lock, restart ignored
  task automatic t_contig();
    src_mode = 0; dst_mode = 0; width = 2; len = 3; nbuf = 2; scope = 1;
    src_base = 32'h1000; dst_base = 32'h2000;
    go();
    chk(lock, 1, "R9 lock");
    do_beat(32'h1000, 32'h2000, "R2");
    do_beat(32'h1004, 32'h2004, "R2");
    src_base = 32'h9000; dst_base = 32'h9900;
    go();
    do_beat(32'h1008, 32'h2008, "R8");
    chk(lock, 1, "R9 lock");
    do_beat(32'h100C, 32'h200C, "R2");
    do_beat(32'h1010, 32'h2010, "R2");
    do_beat(32'h1014, 32'h2014, "R12");
    end_check();
    chk(lock, 0, "R9 idle");
  endtask

  // replay src, contiguous dst, half width, 3 buffers of 2
  task automatic t_replay();
    src_mode = 1; dst_mode = 0; width = 1; len = 2; nbuf = 3; scope = 0;
    src_base = 32'h100; dst_base = 32'h200;
    go();
    for (int b = 0; b < 3; b++) begin
      do_beat(32'h100, 32'h200 + 4*b, "R3");
      do_beat(32'h102, 32'h202 + 4*b, "R3");
      if (b < 2) chk(busy, 1, "R12 busy");
    end
    end_check();
  endtask

  // list src, replay dst, byte width, buffer lock
  task automatic t_list();
    src_mode = 2; dst_mode = 1; width = 0; len = 9; nbuf = 9; scope = 2;
    src_base = 0; dst_base = 32'h700; dptr = 32'h40; nfetch = 0; fetch_lock = 0;
    go();
    chk(dreq, 1, "R4 req");
    wait_active();
    chk(lock, 1, "R10 lock");
    do_beat(32'h3000, 32'h700, "R4");
    do_beat(32'h3001, 32'h701, "R5");
    do_beat(32'h5000, 32'h700, "R4");
    end_check();
    chk(nfetch, 8, "R4 count");
    chk(flog[0], 32'h40, "R4 addr");
    chk(flog[3], 32'h4C, "R4 addr");
    chk(flog[4], 32'h80, "R4 addr");
    chk(flog[7], 32'h8C, "R4 addr");
    chk(fetch_lock, 0, "R10 fetch");
  endtask

  // picture window 3 of 8 on src, byte width
  task automatic t_pip();
    src_mode = 0; dst_mode = 0; width = 0; len = 7; nbuf = 1; scope = 0;
    src_pip = 1; pic_w = 3; img_w = 8; src_base = 32'h10; dst_base = 0;
    go();
    do_beat(32'h10, 0, "R6");
    do_beat(32'h11, 1, "R6");
    do_beat(32'h12, 2, "R6");
    do_beat(32'h18, 3, "R6");
    do_beat(32'h19, 4, "R6");
    do_beat(32'h1A, 5, "R6");
    do_beat(32'h20, 6, "R6");
    end_check();
    src_pip = 0;
  endtask

  // chunk lock, chunk of 2 in a 3-beat buffer
  task automatic t_chunk();
    src_mode = 0; dst_mode = 0; width = 2; len = 3; nbuf = 1; scope = 3; chunk = 2;
    src_base = 0; dst_base = 32'h40;
    go();
    chk(lock, 0, "R11 before");
    do_beat(0, 32'h40, "R11");
    chk(lock, 1, "R11 mid");
    do_beat(4, 32'h44, "R11");
    chk(lock, 0, "R11 gap");
    do_beat(8, 32'h48, "R11");
    chk(lock, 0, "R11 end");
    end_check();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_contig();
    t_replay();
    t_list();
    t_pip();
    t_chunk();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule